// File: doc/BRIEF.md
# SPI Readout CRC-8 Generator

This block keeps an 8-bit cyclic redundancy check over the serial data a sensor front end sends back to its host during register reads. Each time the serial framing logic shifts a bit out on SDO, it raises a strobe. The generator folds that bit into the running checksum, most significant bit first. The checksum is zero after reset. It returns to zero whenever chip select goes inactive (high) or the active-low data-ready output is released. Bits shifted out while the host reads the checksum register itself are left out of the checksum. The checksum register can therefore be read any number of times and gives the same value each time.

When a read of the checksum register starts, the block captures the ones complement of the running checksum. It holds that value for the framing logic to shift out, unchanged, until the next such read.

The block also owns the data-ready output. A new-conversion strobe drives the output low. An output-data-rate tick always releases it. Apart from that tick, one configuration bit selects which read event releases data-ready:
- With the bit clear, completing the read of the least significant conversion byte releases it.
- With the bit set, completing the read of the checksum register releases it.

The data-ready controller is a two-state machine:
- **DRDY_IDLE**: the output is high. The transition *new_sample* moves it to DRDY_VALID.
- **DRDY_VALID**: the output is low. The transition *release* moves it back to DRDY_IDLE. *release* fires on the rate tick, or on the read event that the configuration bit selects. A new-conversion strobe that arrives while in DRDY_VALID is ignored.

Top module: `sdo_crc8_gen`

## Requirements
- R1: After reset, `crc_rd_data` is 8'hFF (the complement of a zero checksum) and `drdy_n` is 1.
- R2: The checksum uses the polynomial x^8+x^5+x^4+1 (tap constant 8'h31) and starts from zero. While `cs_n` is 0, each cycle with `sdo_shift`=1 folds `sdo_bit` into it, most significant bit first.
- R3: A cycle with `crc_rd_start`=1 captures the bitwise complement of the running checksum. The captured value appears on `crc_rd_data` in the following cycle.
- R4: Strobes that arrive while `crc_reg_sel`=1 do not change the checksum, so reading the checksum register twice in a row gives the same value.
- R5: While `crc_en`=0, shift strobes leave the checksum unchanged.
- R6: A cycle with `cs_n`=1 clears the checksum to zero.
- R7: With `drdy_n`=1, a `data_new` pulse drives `drdy_n` to 0 in the next cycle. With `drdy_n`=0, an `odr_tick` pulse returns it to 1 in the next cycle, whatever `drdy_aft_crc` is.
- R8: With `drdy_aft_crc`=0, a `lsb_read_done` pulse releases `drdy_n` to 1, and `crc_read_done` has no effect on it.
- R9: With `drdy_aft_crc`=1, a `crc_read_done` pulse releases `drdy_n` to 1, and `lsb_read_done` has no effect on it.
- R10: The edge on which `drdy_n` is released also clears the checksum to zero.
- R11: `crc_rd_data` holds its value through further shifting until the next `crc_rd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sdo_bit | input | 1 | Bit currently driven on SDO |
| sdo_shift | input | 1 | One-cycle strobe for each SDO bit shifted out |
| crc_en | input | 1 | Checksum enable |
| crc_reg_sel | input | 1 | High while the checksum register is being read |
| crc_rd_start | input | 1 | Pulse at the start of a checksum register read |
| data_new | input | 1 | Pulse when a new conversion result is ready |
| odr_tick | input | 1 | Pulse once per output-data-rate period |
| lsb_read_done | input | 1 | Pulse when the least significant conversion byte has been read |
| crc_read_done | input | 1 | Pulse when the checksum register read has completed |
| drdy_aft_crc | input | 1 | Selects which read event releases data-ready (see R8, R9) |
| crc_rd_data | output | 8 | Captured complemented checksum |
| drdy_n | output | 1 | Data-ready, active low |

## Verification
The bench builds the block with its default parameters: an 8-bit width and tap constant 8'h31. With these values, every checksum can be predicted by long division in the bench against x^8+x^5+x^4+1. The vector table covers one- to three-byte streams, including an all-zero byte, a single trailing one bit, a lone leading one and an all-ones run. These patterns reach both the feedback path and the plain shift path. Directed tests then check each clear source, the exclusion of strobes during checksum reads and the disabled state, and both settings of the release-policy bit.

// File: rtl/sdo_crc_pkg.sv
package sdo_crc_pkg;

    typedef enum logic [0:0] {
        DRDY_IDLE  = 1'b0,
        DRDY_VALID = 1'b1
    } drdy_state_t;

    // One serial step of a left-shifting LFSR, input bit enters at the top.
    function automatic logic [7:0] crc8_step(input logic [7:0] cur,
                                             input logic       din,
                                             input logic [7:0] taps);
        logic fb;
        fb = din ^ cur[7];
        return {cur[6:0], 1'b0} ^ (fb ? taps : 8'h00);
    endfunction

endpackage

// File: rtl/crc_lfsr.sv
module crc_lfsr #(
    parameter int          WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS = 8'h31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             din,
    output logic [WIDTH-1:0] crc_q
);
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic             fb;
    logic [WIDTH-1:0] crc_nxt;

    always_comb begin
        fb      = din ^ crc_q[WIDTH-1];
        crc_nxt = {crc_q[WIDTH-2:0], 1'b0} ^ (fb ? TAPS : ZERO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= ZERO;
        end else if (clr) begin
            crc_q <= ZERO;
        end else if (step) begin
            crc_q <= crc_nxt;
        end
    end
endmodule

// File: rtl/drdy_ctrl.sv
module drdy_ctrl
    import sdo_crc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic data_new,
    input  logic odr_tick,
    input  logic lsb_read_done,
    input  logic crc_read_done,
    input  logic drdy_aft_crc,
    output logic drdy_n,
    output logic release_pulse
);
    drdy_state_t state_q, state_d;
    logic        read_release;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DRDY_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        read_release = drdy_aft_crc ? crc_read_done : lsb_read_done;
        state_d      = state_q;
        unique case (state_q)
            DRDY_IDLE:  if (data_new)                  state_d = DRDY_VALID;
            DRDY_VALID: if (odr_tick || read_release)  state_d = DRDY_IDLE;
            default:                                   state_d = DRDY_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        drdy_n        = (state_q == DRDY_IDLE);
        release_pulse = (state_q == DRDY_VALID) && (state_d == DRDY_IDLE);
    end
endmodule

// File: rtl/crc_readout.sv
module crc_readout #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_start,
    input  logic [WIDTH-1:0] crc_in,
    output logic [WIDTH-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '1;
        end else if (rd_start) begin
            rd_data <= ~crc_in;
        end
    end
endmodule

// File: rtl/sdo_crc8_gen.sv
module sdo_crc8_gen #(
    parameter int               CRC_W    = 8,
    parameter logic [CRC_W-1:0] CRC_TAPS = 8'h31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sdo_bit,
    input  logic             sdo_shift,
    input  logic             crc_en,
    input  logic             crc_reg_sel,
    input  logic             crc_rd_start,
    input  logic             data_new,
    input  logic             odr_tick,
    input  logic             lsb_read_done,
    input  logic             crc_read_done,
    input  logic             drdy_aft_crc,
    output logic [CRC_W-1:0] crc_rd_data,
    output logic             drdy_n
);
    logic             drdy_release;
    logic             crc_clr;
    logic             crc_step;
    logic [CRC_W-1:0] crc_q;

    assign crc_clr  = cs_n | drdy_release;
    assign crc_step = crc_en & sdo_shift & ~crc_reg_sel & ~cs_n;

    drdy_ctrl u_drdy (
        .clk           (clk),
        .rst_n         (rst_n),
        .data_new      (data_new),
        .odr_tick      (odr_tick),
        .lsb_read_done (lsb_read_done),
        .crc_read_done (crc_read_done),
        .drdy_aft_crc  (drdy_aft_crc),
        .drdy_n        (drdy_n),
        .release_pulse (drdy_release)
    );

    crc_lfsr #(.WIDTH(CRC_W), .TAPS(CRC_TAPS)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .step  (crc_step),
        .din   (sdo_bit),
        .crc_q (crc_q)
    );

    crc_readout #(.WIDTH(CRC_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_start (crc_rd_start),
        .crc_in   (crc_q),
        .rd_data  (crc_rd_data)
    );
endmodule

// File: rtl/sdo_crc8_gen_chk.sv
module sdo_crc8_gen_chk #(
    parameter int CRC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             crc_en,
    input logic             crc_rd_start,
    input logic             data_new,
    input logic             odr_tick,
    input logic             lsb_read_done,
    input logic             crc_read_done,
    input logic             drdy_aft_crc,
    input logic             drdy_n,
    input logic [CRC_W-1:0] crc_rd_data,
    input logic [CRC_W-1:0] crc_q
);
    // R5
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc_en && !cs_n && drdy_n) |=> $stable(crc_q));

    // R6
    cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (crc_q == '0));

    // R7
    drdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy_n && data_new) |=> !drdy_n);

    // R7
    odr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drdy_n && odr_tick) |=> drdy_n);

    // R8
    lsb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drdy_n && !drdy_aft_crc && lsb_read_done) |=> drdy_n);

    // R9
    lsb_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drdy_n && drdy_aft_crc && lsb_read_done && !crc_read_done && !odr_tick)
        |=> !drdy_n);

    // R10
    release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drdy_n && odr_tick) |=> (crc_q == '0));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_rd_start |=> $stable(crc_rd_data));
endmodule

bind sdo_crc8_gen sdo_crc8_gen_chk #(.CRC_W(CRC_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .crc_en        (crc_en),
    .crc_rd_start  (crc_rd_start),
    .data_new      (data_new),
    .odr_tick      (odr_tick),
    .lsb_read_done (lsb_read_done),
    .crc_read_done (crc_read_done),
    .drdy_aft_crc  (drdy_aft_crc),
    .drdy_n        (drdy_n),
    .crc_rd_data   (crc_rd_data),
    .crc_q         (crc_q)
);

// File: tb/sdo_crc8_gen_tb_top.sv
`timescale 1ns/1ps
module sdo_crc8_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdo_bit = 1'b0;
    logic       sdo_shift = 1'b0;
    logic       crc_en = 1'b1;
    logic       crc_reg_sel = 1'b0;
    logic       crc_rd_start = 1'b0;
    logic       data_new = 1'b0;
    logic       odr_tick = 1'b0;
    logic       lsb_read_done = 1'b0;
    logic       crc_read_done = 1'b0;
    logic       drdy_aft_crc = 1'b0;
    logic [7:0] crc_rd_data;
    logic       drdy_n;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    sdo_crc8_gen dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .sdo_bit       (sdo_bit),
        .sdo_shift     (sdo_shift),
        .crc_en        (crc_en),
        .crc_reg_sel   (crc_reg_sel),
        .crc_rd_start  (crc_rd_start),
        .data_new      (data_new),
        .odr_tick      (odr_tick),
        .lsb_read_done (lsb_read_done),
        .crc_read_done (crc_read_done),
        .drdy_aft_crc  (drdy_aft_crc),
        .crc_rd_data   (crc_rd_data),
        .drdy_n        (drdy_n)
    );

    // {byte count, message right-aligned}
    localparam logic [25:0] VEC [8] = '{
        {2'd1, 24'h000000},
        {2'd1, 24'h000001},
        {2'd1, 24'h0000FF},
        {2'd1, 24'h000080},
        {2'd2, 24'h00A55A},
        {2'd2, 24'h008000},
        {2'd3, 24'h123456},
        {2'd3, 24'hFFFFFF}
    };

    // Remainder of msg * x^8 divided by x^8+x^5+x^4+1
    function automatic logic [7:0] ref_crc(input logic [23:0] msg, input int nbytes);
        logic [31:0] r;
        r = {msg, 8'h00};
        for (int i = nbytes * 8 + 7; i >= 8; i--) begin
            if (r[i]) r = r ^ (32'h131 << (i - 8));
        end
        return r[7:0];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [23:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdo_bit   = v[i];
            sdo_shift = 1'b1;
            @(negedge clk);
        end
        sdo_shift = 1'b0;
        sdo_bit   = 1'b0;
    endtask

    // Start a read of the checksum register, capture, shift its 8 bits out.
    task automatic read_crc(output logic [7:0] val);
        crc_reg_sel  = 1'b1;
        crc_rd_start = 1'b1;
        @(negedge clk);
        crc_rd_start = 1'b0;
        val = crc_rd_data;
        shift_bits({16'h0, crc_rd_data}, 8);
        crc_reg_sel = 1'b0;
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v1, v2;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rd_data", crc_rd_data, 8'hFF);
        check("R1 drdy_n", {7'd0, drdy_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 vector table
        foreach (VEC[k]) begin
            cs_n = 1'b0;
            shift_bits(VEC[k][23:0], int'(VEC[k][25:24]) * 8);
            read_crc(v1);
            check("R2/R3 vector", v1, ~ref_crc(VEC[k][23:0], int'(VEC[k][25:24])));
            cs_n = 1'b1;
            @(negedge clk);
        end
        check("R2 known 01", ~ref_crc(24'h1, 1), 8'hCE);

        // R4 own-register bits excluded, repeat read stable
        cs_n = 1'b0;
        shift_bits(24'hA5, 8);
        read_crc(v1);
        read_crc(v2);
        check("R4 repeat", v2, v1);
        shift_bits(24'h3C, 8);
        read_crc(v1);
        check("R4 continue", v1, ~ref_crc(24'hA53C, 2));
        cs_n = 1'b1;
        @(negedge clk);

        // R5 disabled
        cs_n = 1'b0;
        shift_bits(24'h12, 8);
        crc_en = 1'b0;
        shift_bits(24'hFF, 8);
        crc_en = 1'b1;
        read_crc(v1);
        check("R5 disabled", v1, ~ref_crc(24'h12, 1));

        // R6 chip select clears
        shift_bits(24'h77, 8);
        cs_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        read_crc(v1);
        check("R6 cs clear", v1, 8'hFF);

        // R11 hold until next start
        shift_bits(24'h01, 8);
        read_crc(v1);
        shift_bits(24'hFF, 8);
        check("R11 hold", crc_rd_data, 8'hCE);

        // R7 set and odr release
        cs_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        pulse(data_new);
        check("R7 set", {7'd0, drdy_n}, 8'h00);
        pulse(odr_tick);
        check("R7 odr", {7'd0, drdy_n}, 8'h01);

        // R8 default policy
        drdy_aft_crc = 1'b0;
        pulse(data_new);
        pulse(crc_read_done);
        check("R8 crc ignored", {7'd0, drdy_n}, 8'h00);
        pulse(lsb_read_done);
        check("R8 lsb release", {7'd0, drdy_n}, 8'h01);

        // R9 release after checksum read
        drdy_aft_crc = 1'b1;
        pulse(data_new);
        pulse(lsb_read_done);
        check("R9 lsb ignored", {7'd0, drdy_n}, 8'h00);
        pulse(crc_read_done);
        check("R9 crc release", {7'd0, drdy_n}, 8'h01);

        // R10 release clears checksum
        drdy_aft_crc = 1'b0;
        pulse(data_new);
        shift_bits(24'h5A, 8);
        pulse(odr_tick);
        read_crc(v1);
        check("R10 release clear", v1, 8'hFF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule